// File: doc/BRIEF.md
# Limit-Match System Counter/Timer

This block is a 32-bit counter/timer that sits on a simple word-wide register bus. A periodic one-cycle `tick` pulse, produced elsewhere, advances a 22-bit count field. The field lives in bits 30..9 of the counter word, so one tick adds 0x200 to the value that software reads. Software programs a limit in the same format. When the count reaches a non-zero limit, the count restarts from zero on that same tick. A sticky reached flag is set and a level interrupt is raised. Both stay up until software reads the limit register. A limit of zero makes the block a free-running counter that wraps at its maximum and never signals.

A second limit address reloads the limit without disturbing the running count. Software uses it to retune the period on the fly. The block also keeps a per-processor mode bitmap. Other logic reads it, and it has no effect on the timer itself. Routing the interrupt to processors and generating the tick are done outside the block.

Top module: `ltmrTop`

## Requirements
- R1: A counter read (byte offset 0x04) returns bit 31 = reached flag, bits 30..9 = count field, and bits 8..0 always zero.
- R2: Each clock with `tick` high adds one to the count field, which is 0x200 in the counter word. Without a tick the count holds.
- R3: With a non-zero limit field L, the tick that would bring the count to L sets it to zero instead, and sets the reached flag and `irq`. Both stay set over later ticks while counting continues, so `irq` first rises on the L-th tick after a restart.
- R4: With a limit of zero the count runs to 0x7FFFFE00, wraps to zero, and never sets the reached flag or `irq`.
- R5: A write to offset 0x00 stores data & 0x7FFFFE00 as the limit, sets the count to zero and lowers `irq`. The reached flag is left as it was.
- R6: A write to offset 0x08 stores data & 0x7FFFFE00 as the limit. The count keeps running and `irq` is unchanged.
- R7: A read of offset 0x00 returns the stored limit, with bit 31 zero. At the end of that cycle it clears the reached flag and `irq`, unless a match occurs on the same cycle, in which case the match wins.
- R8: Writes to 0x04, 0x0C, 0x14, 0x18, 0x1C and to any address with bits 1..0 non-zero change nothing. Reads of 0x08, 0x0C, 0x14..0x1C and of unaligned addresses return zero.
- R9: Offset 0x10 is a read/write mode bitmap of the low 16 data bits. The upper bits read as zero.
- R10: After reset the limit, count, reached flag, `irq` and mode bitmap are all zero.
- R11: A write to offset 0x00 on the same cycle as a tick wins: the count becomes zero and no match is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable pulse |
| busAddr | input | 5 | Byte address within the register window |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (limit read has a side effect) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle `busRdEn` is high |
| irq | output | 1 | Level interrupt on limit match |

## Verification
A table of limit values is run with tick spacings of one to four clocks. The entries include junk low bits, a set bit 31, the smallest limit and a larger one. These tell apart masking errors, an off-by-one in the match point and a count that does not restart on the matching tick. A free-running run, plus a narrow instance that reaches its wrap, separates wrap-to-zero from a false match at the maximum. Directed collisions cover a tick against a limit write and a match against a limit read, and show that each priority is applied the right way round. Accesses to undefined and unaligned addresses are followed by readback of the limit, count and mode to show nothing moved.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  typedef enum logic [2:0] {
    SEL_LIMIT = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_KEEP  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_MODE  = 3'd4,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic limitRst;
    logic limitKeep;
    logic limitAck;
    logic modeWr;
  } ctlStrobe_t;
endpackage

// File: rtl/ltmrCtrl.sv
module ltmrCtrl
  import ltmr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctlStrobe_t        strobes,
  output regSel_e           rdSel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    rdSel   = SEL_NONE;
    if (aligned) begin
      case (int'(wordIdx))
        0: begin
          strobes.limitRst = busWrEn;
          strobes.limitAck = busRdEn;
          if (busRdEn) rdSel = SEL_LIMIT;
        end
        1: if (busRdEn) rdSel = SEL_COUNT;
        2: begin
          strobes.limitKeep = busWrEn;
          if (busRdEn) rdSel = SEL_KEEP;
        end
        3: if (busRdEn) rdSel = SEL_STAT;
        4: begin
          strobes.modeWr = busWrEn;
          if (busRdEn) rdSel = SEL_MODE;
        end
        default: rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ltmrDatapath.sv
module ltmrDatapath
  import ltmr_pkg::*;
#(
  parameter int CNT_W   = 22,
  parameter int CNT_LSB = 9,
  parameter int MODE_W  = 16,
  localparam int DATA_W = CNT_W + CNT_LSB + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  ctlStrobe_t        strobes,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [CNT_W-1:0]  limitField,
  output logic [CNT_W-1:0]  countField,
  output logic              reachedFlag
);
  logic [CNT_W-1:0]  limitQ, countQ, countNext;
  logic [MODE_W-1:0] modeQ;
  logic              reachedQ, irqQ;
  logic              limitZero, matchHit;

  assign countNext = countQ + 1'b1;
  assign limitZero = (limitQ == '0);
  assign matchHit  = tick && !limitZero && (countNext == limitQ) && !strobes.limitRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ   <= '0;
      countQ   <= '0;
      reachedQ <= 1'b0;
      irqQ     <= 1'b0;
      modeQ    <= '0;
    end else begin
      if (strobes.limitRst || strobes.limitKeep)
        limitQ <= wrData[CNT_LSB +: CNT_W];

      if (strobes.limitRst)       countQ <= '0;
      else if (matchHit)          countQ <= '0;
      else if (tick)              countQ <= countNext;

      if (matchHit)               reachedQ <= 1'b1;
      else if (strobes.limitAck)  reachedQ <= 1'b0;

      if (matchHit)               irqQ <= 1'b1;
      else if (strobes.limitAck || strobes.limitRst) irqQ <= 1'b0;

      if (strobes.modeWr)         modeQ <= wrData[MODE_W-1:0];
    end
  end

  always_comb begin
    case (rdSel)
      SEL_LIMIT: rdData = {1'b0, limitQ, {CNT_LSB{1'b0}}};
      SEL_COUNT: rdData = {reachedQ, countQ, {CNT_LSB{1'b0}}};
      SEL_MODE:  rdData = DATA_W'(modeQ);
      default:   rdData = '0;
    endcase
  end

  assign irq         = irqQ;
  assign limitField  = limitQ;
  assign countField  = countQ;
  assign reachedFlag = reachedQ;
endmodule

// File: rtl/ltmrTop.sv
module ltmrTop
  import ltmr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 22,
  parameter int CNT_LSB = 9,
  parameter int MODE_W  = 16,
  localparam int DATA_W = CNT_W + CNT_LSB + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  ctlStrobe_t       strobes;
  regSel_e          rdSel;
  logic [CNT_W-1:0] limitField, countField;
  logic             reachedFlag;

  ltmrCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  ltmrDatapath #(.CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .MODE_W(MODE_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .strobes     (strobes),
    .rdSel       (rdSel),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .irq         (irq),
    .limitField  (limitField),
    .countField  (countField),
    .reachedFlag (reachedFlag)
  );
endmodule

// File: rtl/ltmrChecker.sv
module ltmrChecker #(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 22,
  parameter int CNT_LSB = 9,
  localparam int DATA_W = CNT_W + CNT_LSB + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              irq,
  input logic [CNT_W-1:0]  limitField,
  input logic [CNT_W-1:0]  countField,
  input logic              reachedFlag
);
  logic wrLimit, rdLimit, wrCount;
  assign wrLimit = busWrEn && (busAddr == ADDR_W'(0));
  assign rdLimit = busRdEn && (busAddr == ADDR_W'(0));
  assign wrCount = busWrEn && (busAddr == ADDR_W'(4));

  a_r1_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(4)) |-> (busRdData[CNT_LSB-1:0] == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrLimit) |=> $stable(countField));

  a_r3_irq_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> reachedFlag);

  a_r4_free_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (limitField == '0 && !irq && !reachedFlag) |=> (!irq && !reachedFlag));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    wrLimit |=> (countField == '0 && !irq));

  a_r7_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rdLimit && !tick) |=> (!irq && !reachedFlag));

  a_r8_cnt_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount && !tick) |=> ($stable(countField) && $stable(limitField)));
endmodule

bind ltmrTop ltmrChecker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busRdData   (busRdData),
  .irq         (irq),
  .limitField  (limitField),
  .countField  (countField),
  .reachedFlag (reachedFlag)
);

// File: tb/tb_ltmrTop.sv
`timescale 1ns/100ps
module tb_ltmrTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq;
  logic [13:0] rdW;
  logic        irqW;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  ltmrTop dut (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq)
  );

  // narrow instance: 4-bit count field, so the free-run wrap is reachable
  ltmrTop #(.CNT_W(4), .MODE_W(4)) dutW (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData[13:0]),
    .busRdData(rdW), .irq(irqW)
  );

  // vector: {tick spacing in clocks, limit write data}
  localparam logic [39:0] VEC [5] = '{
    {8'd2, 32'h0000_0BFF},
    {8'd3, 32'h8000_0600},
    {8'd1, 32'h0000_0200},
    {8'd4, 32'h0000_1400},
    {8'd1, 32'h0000_2000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doTicks(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (per - 1) @(negedge clk);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk) busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk) busRdEn = 1'b0;
  endtask

  task automatic busRdW(input logic [4:0] a, output logic [13:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = rdW;
    @(negedge clk) busRdEn = 1'b0;
  endtask

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [13:0] dw;
    logic [31:0] lim;
    int          ticksL;
    int          per;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    busRd(5'h00, d); chk("R10 limit after reset", d, 32'h0);
    busRd(5'h04, d); chk("R10 counter after reset", d, 32'h0);
    busRd(5'h10, d); chk("R10 mode after reset", d, 32'h0);

    // R4 / R2 free-run and wrap (narrow instance wraps at 16 ticks)
    doTicks(15, 2);
    busRd(5'h04, d);  chk("R2 free-run count 15", d, 32'h0000_1E00);
    busRdW(5'h04, dw); chk("R4 narrow count 15", {18'b0, dw}, 32'h0000_1E00);
    busRd(5'h04, d);  chk("R2 count holds without tick", d, 32'h0000_1E00);
    doTicks(1, 1);
    busRdW(5'h04, dw); chk("R4 narrow wraps to zero", {18'b0, dw}, 32'h0);
    chk("R4 no irq in free-run", {30'b0, irq, irqW}, 32'h0);
    busRd(5'h04, d);  chk("R1 count 16 format", d, 32'h0000_2000);

    // R3 / R5 / R7 table of limits and tick spacings
    foreach (VEC[k]) begin
      lim    = VEC[k][31:0] & 32'h7FFF_FE00;
      ticksL = int'(lim >> 9);
      per    = int'(VEC[k][39:32]);
      busWr(5'h00, VEC[k][31:0]);
      busRd(5'h04, d); chk("R5 limit write restarts count", d, 32'h0);
      if (ticksL > 1) begin
        doTicks(ticksL - 1, per);
        chk("R3 no irq before limit", {31'b0, irq}, 32'h0);
        busRd(5'h04, d); chk("R1 count before limit", d, (ticksL - 1) << 9);
      end
      doTicks(1, per);
      chk("R3 irq at limit tick", {31'b0, irq}, 32'h1);
      busRd(5'h04, d); chk("R3 count zero and reached", d, 32'h8000_0000);
      doTicks(1, per);
      busRd(5'h04, d); chk("R3 keeps counting, flag sticky", d, 32'h8000_0000 | ((1 % ticksL) << 9));
      chk("R3 irq sticky", {31'b0, irq}, 32'h1);
      busRd(5'h00, d); chk("R7 limit readback masked", d, lim);
      chk("R7 read acks irq", {31'b0, irq}, 32'h0);
      busRd(5'h04, d); chk("R7 read clears reached", d, (1 % ticksL) << 9);
    end

    // R6 reload without restart
    busWr(5'h00, 32'h0000_2800);
    doTicks(4, 1);
    busWr(5'h08, 32'h0000_0DFF);
    busRd(5'h04, d); chk("R6 count survives reload", d, 32'h0000_0800);
    busRd(5'h00, d); chk("R6 reloaded limit masked", d, 32'h0000_0C00);
    doTicks(1, 1);
    chk("R6 no irq at 5", {31'b0, irq}, 32'h0);
    doTicks(1, 1);
    chk("R6 irq at new limit", {31'b0, irq}, 32'h1);
    busWr(5'h08, 32'h0000_0C00);
    chk("R6 reload leaves irq", {31'b0, irq}, 32'h1);

    // R5 limit write drops irq but keeps reached
    busWr(5'h00, 32'h0000_0600);
    chk("R5 limit write drops irq", {31'b0, irq}, 32'h0);
    busRd(5'h04, d); chk("R5 reached kept", d, 32'h8000_0000);
    busRd(5'h00, d);

    // R7 match and ack on the same cycle: match wins
    busWr(5'h00, 32'h0000_0400);
    doTicks(1, 1);
    @(negedge clk); tick = 1'b1; busAddr = 5'h00; busRdEn = 1'b1;
    @(negedge clk); tick = 1'b0; busRdEn = 1'b0;
    chk("R7 match beats ack", {31'b0, irq}, 32'h1);
    busRd(5'h00, d);
    chk("R7 later ack clears", {31'b0, irq}, 32'h0);

    // R11 limit write beats tick
    busWr(5'h00, 32'h0000_0600);
    doTicks(2, 1);
    @(negedge clk); tick = 1'b1; busAddr = 5'h00; busWrData = 32'h0000_0600; busWrEn = 1'b1;
    @(negedge clk); tick = 1'b0; busWrEn = 1'b0;
    chk("R11 no match on write cycle", {31'b0, irq}, 32'h0);
    busRd(5'h04, d); chk("R11 count zero after collision", d, 32'h0);
    doTicks(2, 1);
    chk("R11 no irq at 2", {31'b0, irq}, 32'h0);
    doTicks(1, 1);
    chk("R11 irq after full period", {31'b0, irq}, 32'h1);
    busRd(5'h00, d);

    // R9 mode bitmap
    busWr(5'h10, 32'hFFFF_A5C3);
    busRd(5'h10, d); chk("R9 mode low bits only", d, 32'h0000_A5C3);

    // R8 ignored writes and zero reads
    busWr(5'h00, 32'h0000_1000);
    doTicks(3, 1);
    busWr(5'h04, 32'hFFFF_FFFF);
    busWr(5'h0C, 32'hFFFF_FFFF);
    busWr(5'h14, 32'hFFFF_FFFF);
    busWr(5'h18, 32'hFFFF_FFFF);
    busWr(5'h1C, 32'hFFFF_FFFF);
    busWr(5'h01, 32'hFFFF_FFFF);
    busWr(5'h12, 32'h0000_0000);
    busRd(5'h04, d); chk("R8 counter write ignored", d, 32'h0000_0600);
    busRd(5'h00, d); chk("R8 limit untouched", d, 32'h0000_1000);
    busRd(5'h10, d); chk("R8 mode untouched", d, 32'h0000_A5C3);
    busRd(5'h08, d); chk("R8 read 0x08 zero", d, 32'h0);
    busRd(5'h0C, d); chk("R8 read 0x0C zero", d, 32'h0);
    busRd(5'h14, d); chk("R8 read 0x14 zero", d, 32'h0);
    busRd(5'h1C, d); chk("R8 read 0x1C zero", d, 32'h0);
    busRd(5'h02, d); chk("R8 unaligned read zero", d, 32'h0);

    finishRun();
  end
endmodule